// File: doc/BRIEF.md
# Line Burst Transfer Adapter

This block connects a 128-bit system data path to a 32-bit memory data path that can only move whole bursts. Each request, whatever its size, is turned into a single 32-byte line transfer. On the system side the line crosses as two 16-byte beats. On the memory side it crosses as eight 4-byte longword beats. The first memory beat carries the longword that holds the requested address, and the following beats step through the line with wrap-around.

On a write, both system beats are gathered first. The eight memory beats are then issued, each with a per-byte inhibit mask that protects every byte outside the requested range. On a read, each arriving longword is stored with the unrequested bytes cleared. Each 16-byte half goes back to the requester as soon as its four longwords are present.

A request that names an unknown size, or that would run past the end of its 32-byte line, is rejected with an error pulse and is never executed. Requests are taken only while the block is idle.

Top module: `line_burst_adapter`

## Requirements
- R1: `req_ready` is high exactly while the block is idle. A request is taken on a cycle where `req_valid` and `req_ready` are both high. While a transfer is running, `sys_wready`, `mem_valid` or `sys_rvalid` may be high, but never together with `req_ready`.
- R2: The `req_size` codes are 0 for 1 byte, 1 for 2 bytes, 2 for 4 bytes, 3 for 16 bytes and 4 for 32 bytes. A taken request is rejected if its code is 5, 6 or 7, or if its line offset `req_addr[4:0]` plus its byte count exceeds 32. A rejected request gives a one-cycle `req_err` pulse in the cycle after it is taken. No memory beat is issued, `xfer_done` stays low and `req_ready` stays high.
- R3: After a write request is taken, the block takes exactly two system beats, with `sys_wready` high. The first beat fills the line half selected by `req_addr[4]` and the second beat fills the other half. Byte k of a beat sits at bits [8k+7:8k].
- R4: Every accepted transfer issues exactly eight memory beats. `mem_lw` of the first beat equals `req_addr[4:2]`, and each later beat's `mem_lw` is the previous one plus 1, modulo 8. `mem_line` equals `req_addr[ADDR_W-1:5]` and `mem_write` equals the request direction.
- R5: On a write beat for longword L, `mem_wdata` holds line bytes 4L to 4L+3, with byte j at bits [8j+7:8j]. `mem_mask` bit j is 1, meaning do not write, exactly when line byte 4L+j lies outside the requested range.
- R6: On a read, `mem_rdata` is captured on each memory handshake. In the data returned on `sys_rdata`, every byte outside the requested range reads as zero.
- R7: A read half is offered on `sys_rvalid` in the cycle after the memory handshake that completes its four longwords. `sys_rhalf` names the half (0 for bytes 0-15, 1 for bytes 16-31), and `sys_rdata` carries byte k of that half at bits [8k+7:8k]. Each half is offered once. If both halves are waiting and neither is already being offered, half 0 goes first.
- R8: `xfer_done` pulses for one cycle in the cycle after the final handshake of a transfer. For a write, that is the eighth memory beat. For a read, it is the later of the eighth memory beat and the second system read beat. `req_ready` is high in that same cycle.
- R9: While `mem_valid` is high and `mem_ready` is low, `mem_lw`, `mem_wdata` and `mem_mask` hold their values into the next cycle. While `sys_rvalid` is high and `sys_rready` is low, `sys_rvalid`, `sys_rhalf` and `sys_rdata` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the request |
| req_size | input | 3 | Size code (see R2) |
| req_err | output | 1 | Rejected-request pulse |
| xfer_done | output | 1 | Transfer complete pulse |
| sys_wvalid | input | 1 | System write beat present |
| sys_wready | output | 1 | System write beat taken |
| sys_wdata | input | 128 | System write beat data |
| sys_rvalid | output | 1 | System read beat present |
| sys_rready | input | 1 | Requester takes read beat |
| sys_rdata | output | 128 | System read beat data |
| sys_rhalf | output | 1 | Line half carried by the read beat |
| mem_valid | output | 1 | Memory beat present |
| mem_ready | input | 1 | Memory completes the beat |
| mem_write | output | 1 | Direction of the burst |
| mem_line | output | ADDR_W-5 | Line number of the burst |
| mem_lw | output | 3 | Longword index of the current beat |
| mem_wdata | output | 32 | Write data of the current beat |
| mem_mask | output | 4 | Per-byte write inhibit, 1 = do not write |
| mem_rdata | input | 32 | Read data, valid on the memory handshake |

## Verification
A wrong start index or a broken wrap counter shows at once on `mem_lw` of the first or next memory beat. A stale or wrong byte-range register shows in the same beat as a wrong `mem_mask` bit on writes. On reads it shows as nonzero filler bytes in the returned half. A corrupted arrival record for the halves shows as `sys_rvalid` rising one or more cycles too early or too late. A lost completion state shows as a missing or misplaced `xfer_done` pulse in the cycle after the final handshake. The bench compares every one of these outputs cycle by cycle against its own model, including start points that wrap and halves that finish in either order.

// File: rtl/line_burst_adapter.sv
module line_burst_adapter #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [2:0]        req_size,
  output logic              req_err,
  output logic              xfer_done,
  input  logic              sys_wvalid,
  output logic              sys_wready,
  input  logic [127:0]      sys_wdata,
  output logic              sys_rvalid,
  input  logic              sys_rready,
  output logic [127:0]      sys_rdata,
  output logic              sys_rhalf,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_write,
  output logic [ADDR_W-6:0] mem_line,
  output logic [2:0]        mem_lw,
  output logic [31:0]       mem_wdata,
  output logic [3:0]        mem_mask,
  input  logic [31:0]       mem_rdata
);

  localparam int LINE_B = 32;
  localparam int LAST_BEAT = 7;

  typedef enum logic [1:0] {S_IDLE, S_GATHER, S_BURST, S_DRAIN} st_t;

  st_t               st;
  logic              wr;
  logic [ADDR_W-6:0] line_q;
  logic [2:0]        start_lw, cnt;
  logic [31:0]       ben;
  logic [255:0]      buffer;
  logic [7:0]        got;
  logic [1:0]        sent;
  logic              wbeat, hold_v, hold_h;

  logic [5:0]  nbytes;
  logic        bad, accept;
  logic [31:0] req_ben;
  logic [1:0]  pend;
  logic [3:0]  lane_en;
  logic [31:0] lane_keep;

  always_comb begin
    case (req_size)
      3'd0:    nbytes = 6'd1;
      3'd1:    nbytes = 6'd2;
      3'd2:    nbytes = 6'd4;
      3'd3:    nbytes = 6'd16;
      3'd4:    nbytes = 6'd32;
      default: nbytes = 6'd0;
    endcase
  end

  assign bad     = (nbytes == 6'd0) || (({1'b0, req_addr[4:0]} + nbytes) > 6'(LINE_B));
  assign req_ben = 32'(((64'd1 << nbytes) - 64'd1) << req_addr[4:0]);
  assign accept  = req_valid && req_ready;

  assign req_ready  = (st == S_IDLE);
  assign sys_wready = (st == S_GATHER);
  assign mem_valid  = (st == S_BURST);
  assign mem_write  = wr;
  assign mem_line   = line_q;
  assign mem_lw     = start_lw + cnt;
  assign mem_wdata  = buffer[{mem_lw, 5'd0} +: 32];
  assign lane_en    = ben[{mem_lw, 2'd0} +: 4];
  assign mem_mask   = ~lane_en;
  assign lane_keep  = {{8{lane_en[3]}}, {8{lane_en[2]}}, {8{lane_en[1]}}, {8{lane_en[0]}}};

  assign pend       = {&got[7:4], &got[3:0]} & ~sent;
  assign sys_rvalid = !wr && (st == S_BURST || st == S_DRAIN) && (|pend);
  assign sys_rhalf  = hold_v ? hold_h : !pend[0];
  assign sys_rdata  = buffer[{sys_rhalf, 7'd0} +: 128];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      wr        <= 1'b0;
      line_q    <= '0;
      start_lw  <= '0;
      cnt       <= '0;
      ben       <= '0;
      got       <= '0;
      sent      <= '0;
      wbeat     <= 1'b0;
      hold_v    <= 1'b0;
      hold_h    <= 1'b0;
      req_err   <= 1'b0;
      xfer_done <= 1'b0;
    end else begin
      req_err   <= 1'b0;
      xfer_done <= 1'b0;
      hold_v    <= sys_rvalid && !sys_rready;
      hold_h    <= sys_rhalf;
      case (st)
        S_IDLE: if (accept) begin
          if (bad) begin
            req_err <= 1'b1;
          end else begin
            wr       <= req_write;
            line_q   <= req_addr[ADDR_W-1:5];
            start_lw <= req_addr[4:2];
            ben      <= req_ben;
            cnt      <= '0;
            got      <= '0;
            sent     <= '0;
            wbeat    <= 1'b0;
            st       <= req_write ? S_GATHER : S_BURST;
          end
        end
        S_GATHER: if (sys_wvalid) begin
          wbeat <= 1'b1;
          if (wbeat) st <= S_BURST;
        end
        S_BURST: if (mem_ready) begin
          cnt         <= cnt + 3'd1;
          got[mem_lw] <= 1'b1;
          if (cnt == 3'(LAST_BEAT)) begin
            if (wr) begin
              st        <= S_IDLE;
              xfer_done <= 1'b1;
            end else begin
              st <= S_DRAIN;
            end
          end
        end
        default: ;
      endcase
      if (sys_rvalid && sys_rready) begin
        sent[sys_rhalf] <= 1'b1;
        if (st == S_DRAIN && (sent | (2'b01 << sys_rhalf)) == 2'b11) begin
          st        <= S_IDLE;
          xfer_done <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (st == S_GATHER && sys_wvalid)
      buffer[{start_lw[2] ^ wbeat, 7'd0} +: 128] <= sys_wdata;
    else if (st == S_BURST && mem_ready && !wr)
      buffer[{mem_lw, 5'd0} +: 32] <= mem_rdata & lane_keep;
  end

  AST_IDLE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !(mem_valid || sys_wready || sys_rvalid)) else $error("idle overlap"); // R1
  AST_BAD_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    accept && bad |=> req_err && req_ready && !mem_valid) else $error("bad request ran"); // R2
  AST_GOOD_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !bad |=> !req_err && !req_ready) else $error("good request flagged"); // R2
  AST_CRIT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !bad && !req_write |=> mem_valid && mem_lw == $past(req_addr[4:2])) else $error("start longword"); // R4
  AST_LW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_ready |=> !mem_valid || mem_lw == $past(mem_lw) + 3'd1) else $error("wrap order"); // R4
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_lw) && $stable(mem_wdata) && $stable(mem_mask)) else $error("mem hold"); // R9
  AST_SYS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rvalid && !sys_rready |=> sys_rvalid && $stable(sys_rhalf) && $stable(sys_rdata)) else $error("sys hold"); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> req_ready && !req_err) else $error("done not idle"); // R8

endmodule

// File: tb/line_burst_adapter_test.sv
`timescale 1ns/1ps
module line_burst_adapter_test;
  localparam int AW = 32;
  localparam time CLK_P = 20ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0;
  logic [AW-1:0] req_addr = '0;
  logic [2:0] req_size = '0;
  logic req_ready, req_err, xfer_done;
  logic sys_wvalid = 0, sys_wready;
  logic [127:0] sys_wdata = '0;
  logic sys_rvalid, sys_rready = 0, sys_rhalf;
  logic [127:0] sys_rdata;
  logic mem_valid, mem_ready = 0, mem_write;
  logic [AW-6:0] mem_line;
  logic [2:0] mem_lw;
  logic [31:0] mem_wdata, mem_rdata = '0;
  logic [3:0] mem_mask;

  int total = 0, fails = 0;

  line_burst_adapter #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
    .req_err(req_err), .xfer_done(xfer_done), .sys_wvalid(sys_wvalid),
    .sys_wready(sys_wready), .sys_wdata(sys_wdata), .sys_rvalid(sys_rvalid),
    .sys_rready(sys_rready), .sys_rdata(sys_rdata), .sys_rhalf(sys_rhalf),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
    .mem_line(mem_line), .mem_lw(mem_lw), .mem_wdata(mem_wdata),
    .mem_mask(mem_mask), .mem_rdata(mem_rdata));

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int size_bytes(input logic [2:0] s);
    case (s)
      3'd0: return 1;
      3'd1: return 2;
      3'd2: return 4;
      3'd3: return 16;
      default: return 32;
    endcase
  endfunction

  function automatic bit in_req(input int b, input int off, input int n);
    return (b >= off) && (b < off + n);
  endfunction

  function automatic logic [7:0] wpat(input int b, input int seed);
    return 8'(b * 7 + seed);
  endfunction

  function automatic logic [7:0] rpat(input int b, input int seed);
    return 8'((b * 3) ^ 8'hA5) + 8'(seed);
  endfunction

  task automatic send_req(input bit w, input logic [AW-1:0] a, input logic [2:0] s);
    @(negedge clk);
    chk(req_ready === 1'b1, "R1", "ready before request", 128'(req_ready), 128'd1);
    req_valid = 1; req_write = w; req_addr = a; req_size = s;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [2:0] s, input bit stall, input int seed);
    int off = int'(a[4:0]);
    int n = size_bytes(s);
    int st_lw = int'(a[4:2]);
    int beats = 0, cyc = 0;
    bit pv = 0, pr = 0;
    logic [2:0] plw = '0; logic [31:0] pd = '0; logic [3:0] pm = '0;
    send_req(1'b1, a, s);
    chk(req_ready === 1'b0 && req_err === 1'b0, "R1", "busy after write request", 128'(req_ready), 128'd0);
    for (int hb = 0; hb < 2; hb++) begin
      int h = (int'(a[4]) + hb) % 2;
      logic [127:0] d;
      for (int k = 0; k < 16; k++) d[8*k +: 8] = wpat(16*h + k, seed);
      if (hb == 1) @(negedge clk);
      chk(sys_wready === 1'b1, "R3", "sys_wready for write beat", 128'(sys_wready), 128'd1);
      sys_wvalid = 1; sys_wdata = d;
      @(posedge clk);
    end
    @(negedge clk);
    sys_wvalid = 0;
    while (beats < 8 && cyc < 100) begin
      if (cyc > 0) @(negedge clk);
      cyc++;
      if (pv && !pr)
        chk(mem_valid && mem_lw == plw && mem_wdata == pd && mem_mask == pm, "R9", "write beat held under stall",
            128'({mem_lw, mem_wdata, mem_mask}), 128'({plw, pd, pm}));
      mem_ready = stall ? (cyc % 3 != 0) : 1'b1;
      if (mem_valid && mem_ready) begin
        int lw = (st_lw + beats) % 8;
        logic [31:0] ed; logic [3:0] em;
        for (int j = 0; j < 4; j++) begin
          ed[8*j +: 8] = wpat(4*lw + j, seed);
          em[j] = !in_req(4*lw + j, off, n);
        end
        chk(mem_lw == 3'(lw), "R4", "write beat longword order", 128'(mem_lw), 128'(lw));
        chk(mem_write === 1'b1 && mem_line == a[AW-1:5], "R4", "write direction and line", 128'({mem_write, mem_line}), 128'({1'b1, a[AW-1:5]}));
        chk(mem_wdata == ed, "R5", "write beat data", 128'(mem_wdata), 128'(ed));
        chk(mem_mask == em, "R5", "write beat mask", 128'(mem_mask), 128'(em));
        beats++;
      end
      pv = mem_valid; pr = mem_ready; plw = mem_lw; pd = mem_wdata; pm = mem_mask;
    end
    @(negedge clk);
    mem_ready = 0;
    chk(xfer_done === 1'b1 && req_ready === 1'b1, "R8", "write done after eighth beat", 128'({xfer_done, req_ready}), 128'd3);
    @(negedge clk);
    chk(xfer_done === 1'b0 && mem_valid === 1'b0, "R8", "single done pulse, no ninth beat", 128'({xfer_done, mem_valid}), 128'd0);
  endtask

  task automatic do_read(input logic [AW-1:0] a, input logic [2:0] s, input bit mstall, input bit rhold, input int seed);
    int off = int'(a[4:0]);
    int n = size_bytes(s);
    int st_lw = int'(a[4:2]);
    int beats = 0, cyc = 0;
    bit [7:0] got = '0;
    bit [1:0] sent = '0;
    bit exp_done = 0, seen_done = 0, poff = 0, ph = 0;
    send_req(1'b0, a, s);
    chk(req_err === 1'b0 && mem_valid === 1'b1 && mem_lw == a[4:2], "R4", "critical longword first", 128'({mem_valid, mem_lw}), 128'({1'b1, a[4:2]}));
    while (!seen_done && cyc < 150) begin
      bit [1:0] pend;
      bit eh;
      if (cyc > 0) @(negedge clk);
      cyc++;
      pend = {&got[7:4], &got[3:0]} & ~sent;
      chk(xfer_done === exp_done, "R8", "read done timing", 128'(xfer_done), 128'(exp_done));
      if (exp_done) begin seen_done = 1; mem_ready = 0; sys_rready = 0; break; end
      chk(sys_rvalid === (|pend), "R7", "read half offered when complete", 128'(sys_rvalid), 128'(|pend));
      eh = poff ? ph : !pend[0];
      if (sys_rvalid) begin
        logic [127:0] ed;
        for (int k = 0; k < 16; k++)
          ed[8*k +: 8] = in_req(16*int'(eh) + k, off, n) ? rpat(16*int'(eh) + k, seed) : 8'h00;
        chk(sys_rhalf === eh, "R7", "read half selection", 128'(sys_rhalf), 128'(eh));
        chk(sys_rdata == ed, "R6", "read data with dropped bytes", sys_rdata, ed);
      end
      mem_ready = mstall ? (cyc % 2 == 0) : 1'b1;
      for (int j = 0; j < 4; j++) mem_rdata[8*j +: 8] = rpat(4*int'(mem_lw) + j, seed);
      sys_rready = rhold ? (beats == 8 && cyc % 2 == 0) : 1'b1;
      if (mem_valid && mem_ready) begin
        int lw = (st_lw + beats) % 8;
        chk(mem_lw == 3'(lw) && mem_write === 1'b0 && mem_line == a[AW-1:5], "R4", "read beat order",
            128'({mem_write, mem_line, mem_lw}), 128'({1'b0, a[AW-1:5], 3'(lw)}));
        got[lw] = 1; beats++;
      end
      poff = sys_rvalid && !sys_rready; ph = sys_rhalf;
      if (sys_rvalid && sys_rready) sent[sys_rhalf] = 1;
      exp_done = (beats == 8) && (sent == 2'b11);
    end
    chk(seen_done && beats == 8, "R8", "read finished with eight beats", 128'({seen_done, 4'(beats)}), 128'({1'b1, 4'd8}));
    @(negedge clk);
    chk(xfer_done === 1'b0 && req_ready === 1'b1, "R8", "read idle after done", 128'({xfer_done, req_ready}), 128'd1);
  endtask

  task automatic do_bad(input bit w, input logic [AW-1:0] a, input logic [2:0] s);
    bit any = 0;
    send_req(w, a, s);
    chk(req_err === 1'b1 && req_ready === 1'b1, "R2", "reject pulse", 128'({req_err, req_ready}), 128'd3);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (mem_valid || sys_wready || xfer_done || req_err || !req_ready) any = 1;
    end
    chk(!any, "R2", "rejected request not executed", 128'(any), 128'd0);
  endtask

  initial begin
    #(CLK_P * 100000);
    fails++; total++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready === 1'b1 && mem_valid === 1'b0 && sys_rvalid === 1'b0 && sys_wready === 1'b0,
        "R1", "reset state", 128'({req_ready, mem_valid, sys_rvalid, sys_wready}), 128'b1000);
    chk(req_err === 1'b0 && xfer_done === 1'b0, "R8", "no pulses in reset", 128'({req_err, xfer_done}), 128'd0);
    rst_n = 1;
    do_write(32'h0000_1005, 3'd0, 1'b0, 3);
    do_write(32'h0000_2016, 3'd1, 1'b1, 11);
    do_write(32'h0000_3010, 3'd3, 1'b0, 29);
    do_write(32'h0000_4000, 3'd4, 1'b1, 5);
    do_write(32'h0000_501C, 3'd2, 1'b0, 17);
    do_read(32'h0000_6014, 3'd2, 1'b0, 1'b0, 1);
    do_read(32'h0000_7000, 3'd4, 1'b0, 1'b1, 9);
    do_read(32'h0000_800A, 3'd1, 1'b1, 1'b0, 21);
    do_read(32'h0000_9013, 3'd0, 1'b1, 1'b1, 40);
    do_read(32'h0000_A00C, 3'd3, 1'b0, 1'b0, 7);
    do_bad(1'b1, 32'h0000_B01F, 3'd1);
    do_bad(1'b0, 32'h0000_B011, 3'd3);
    do_bad(1'b0, 32'h0000_B000, 3'd5);
    do_bad(1'b1, 32'h0000_B001, 3'd4);
    do_read(32'h0000_C01C, 3'd2, 1'b0, 1'b0, 60);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule